// File: doc/BRIEF.md
# Banked PLL Configuration Register Bank

This block is the software-facing configuration front end for a group of up to eight phase-locked loops. All instances share one small register window on a simple word-addressed bus. Software first writes an instance number into the selection register. Reads and writes of the control and analog registers then reach that instance's staged copy. The settings take effect only when software writes the selection register again with the commit bit set. That write copies the staged values of the named instance into its live values, and the live values drive the PLL through output ports.

Each instance holds a multiplier, a 22-bit fractional part, an output divider and its enable bits. The output ratio of an instance is (mul+1) + frac/2^22, and its output divides by div+1. Each instance also holds two analog supply enables. A lock counter per instance stands in for the analog lock behaviour. When a commit starts the PLL, or changes its ratio while it runs, the lock flag of that instance clears and is set again after a fixed number of cycles. A status register collects the lock flags so that software can poll after a commit.

Top module: `pll_cfg_bank`

## Requirements
- R1: After a synchronous active-low reset, every staged and live field, every enable and every lock flag is zero, the selection is instance 0, and every register reads zero.
- R2: A write to offset 0 with bit 8 clear and an instance number ID in bits [3:0] selects instance ID. Offset 0 then reads back ID in bits [3:0], and no live value changes.
- R3: A write to offset 0 whose ID is NUM_PLL or higher (8 to 15 by default) is ignored, even with bit 8 set. The selection and every live value stay as they were.
- R4: Offset 1 holds the staged divider in bits [7:0], divider enable in bit 8, PLL enable in bit 9 and lock-detect enable in bit 10. All other bits read zero. Reads and writes reach only the selected instance.
- R5: Offset 2 holds the staged multiplier in bits [31:24] and the staged fraction in bits [21:0]. Bits [23:22] read zero.
- R6: Offset 3 holds the staged bandgap enable in bit 0 and the staged regulator enable in bit 1. All other bits read zero.
- R7: A write to offset 0 with bit 8 set and a valid ID selects that instance. At the same clock edge it copies all of that instance's staged fields to its live outputs, and no other instance changes.
- R8: The live outputs of an instance change only at a commit of that instance. Staged writes leave them unchanged.
- R9: A commit with PLL enable set clears that instance's lock flag when the PLL was off before, or when mul or frac differs from the live value. The flag then sets exactly LOCK_CYCLES clock edges after the commit edge.
- R10: A commit with PLL enable set that keeps the live mul and frac, such as a divider change, leaves the lock flag and any count in progress as they are.
- R11: A commit with PLL enable clear stops the instance. Its lock flag is clear from the next edge on and stays clear.
- R12: Offset 4 is read-only. Bit n reads the lock flag of instance n, which is also driven on lock_o[n]. A flag shows only while the live lock-detect enable of that instance is set. Writes to offset 4 are ignored.
- R13: Each instance has its own lock counter and lock flag. A commit to one instance does not change the lock flag of another.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_en | input | 1 | Access strobe, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Word offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from bus_addr |
| live_mul_o | output | NUM_PLL*8 | Live multipliers, instance n at [n*8 +: 8] |
| live_frac_o | output | NUM_PLL*22 | Live fractions, instance n at [n*22 +: 22] |
| live_div_o | output | NUM_PLL*8 | Live output dividers, instance n at [n*8 +: 8] |
| div_en_o | output | NUM_PLL | Live divider enables |
| pll_en_o | output | NUM_PLL | Live PLL enables |
| bandgap_en_o | output | NUM_PLL | Live bandgap enables |
| regulator_en_o | output | NUM_PLL | Live regulator enables |
| lock_o | output | NUM_PLL | Lock flags, gated by the lock-detect enable |

## Verification
The assertions check some behaviour on every cycle. A commit copies the staged fields into the live ones on the next edge. Without a commit the live fields stay unchanged. A rejected instance number leaves the selection as it was. A stop commit clears the lock flag. A ratio change restarts the count. A lock flag rises only when its counter runs out. Other behaviour only the bench scenarios can show: the exact field layout of each register, the exact lock delay in cycles, that a divider-only commit keeps the lock, and that the lock-detect enable gates the flag. The same goes for keeping instances apart, where the bench programs one instance and then reads and commits another.

// File: rtl/pll_cfg_pkg.sv
// Package: shared register layout and configuration record for the PLL bank.
// Assumes a 32-bit data bus and word offsets decoded on 3 address bits.
package pll_cfg_pkg;
    localparam int DATA_W     = 32;
    localparam int ADDR_W     = 3;
    localparam int MUL_W      = 8;
    localparam int FRAC_W     = 22;
    localparam int DIV_W      = 8;
    localparam int ID_FIELD_W = 4;
    localparam int MUL_LSB    = DATA_W - MUL_W;
    localparam int COMMIT_BIT = 8;
    localparam int DIVEN_BIT  = 8;
    localparam int PLLEN_BIT  = 9;
    localparam int LOCKEN_BIT = 10;
    localparam int BGAP_BIT   = 0;
    localparam int VREG_BIT   = 1;

    typedef enum logic [ADDR_W-1:0] {
        OFS_SELECT = 3'd0,
        OFS_CTRLA  = 3'd1,
        OFS_RATIO  = 3'd2,
        OFS_ANALOG = 3'd3,
        OFS_STATUS = 3'd4
    } reg_ofs_e;

    typedef struct packed {
        logic [MUL_W-1:0]  mul;
        logic [FRAC_W-1:0] frac;
        logic [DIV_W-1:0]  div;
        logic              div_en;
        logic              pll_en;
        logic              lock_en;
        logic              bgap_en;
        logic              vreg_en;
    } pll_cfg_t;

    // Build the control-A word from a record.
    function automatic logic [DATA_W-1:0] pack_ctrla(input pll_cfg_t c);
        logic [DATA_W-1:0] w;
        w = '0;
        w[DIV_W-1:0]  = c.div;
        w[DIVEN_BIT]  = c.div_en;
        w[PLLEN_BIT]  = c.pll_en;
        w[LOCKEN_BIT] = c.lock_en;
        return w;
    endfunction

    // Build the ratio word from a record.
    function automatic logic [DATA_W-1:0] pack_ratio(input pll_cfg_t c);
        logic [DATA_W-1:0] w;
        w = '0;
        w[DATA_W-1:MUL_LSB] = c.mul;
        w[FRAC_W-1:0]       = c.frac;
        return w;
    endfunction

    // Build the analog word from a record.
    function automatic logic [DATA_W-1:0] pack_analog(input pll_cfg_t c);
        logic [DATA_W-1:0] w;
        w = '0;
        w[BGAP_BIT] = c.bgap_en;
        w[VREG_BIT] = c.vreg_en;
        return w;
    endfunction
endpackage

// File: rtl/pll_cfg_decode.sv
// Module: bus decode and instance selection for the PLL bank.
// Holds the selected instance number, turns bus writes into per-register
// strobes, and flags a commit together with the instance it names.
// Assumes one access per bus_en cycle; out-of-range numbers are dropped.
module pll_cfg_decode
    import pll_cfg_pkg::*;
#(
    parameter int NUM_PLL = 8,
    localparam int SEL_W  = $clog2(NUM_PLL)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_en,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [SEL_W-1:0]  sel_o,
    output logic              wr_ctrla_o,
    output logic              wr_ratio_o,
    output logic              wr_analog_o,
    output logic              commit_o,
    output logic [SEL_W-1:0]  commit_id_o
);
    localparam logic [ID_FIELD_W-1:0] MAX_ID = ID_FIELD_W'(NUM_PLL - 1);

    logic                  wr_any;
    logic                  wr_select;
    logic [ID_FIELD_W-1:0] id_field;
    logic                  id_ok;
    logic [SEL_W-1:0]      sel_q;

    // Classify the current bus write by offset.
    always_comb begin
        wr_any      = bus_en && bus_we;
        wr_select   = wr_any && (bus_addr == OFS_SELECT);
        wr_ctrla_o  = wr_any && (bus_addr == OFS_CTRLA);
        wr_ratio_o  = wr_any && (bus_addr == OFS_RATIO);
        wr_analog_o = wr_any && (bus_addr == OFS_ANALOG);
        id_field    = bus_wdata[ID_FIELD_W-1:0];
        id_ok       = (id_field <= MAX_ID);
        commit_o    = wr_select && id_ok && bus_wdata[COMMIT_BIT];
        commit_id_o = id_field[SEL_W-1:0];
    end

    // Hold the selected instance; accept only valid instance numbers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q <= '0;
        end else if (wr_select && id_ok) begin
            sel_q <= id_field[SEL_W-1:0];
        end
    end

    assign sel_o = sel_q;

    // R3: an out-of-range number leaves the selection untouched.
    assert_bad_id_ignored_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_select && (id_field > MAX_ID)) |=> $stable(sel_q));

    // R2: a valid select write is visible on the next cycle.
    assert_select_taken_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_select && id_ok) |=> (sel_q == $past(id_field[SEL_W-1:0])));
endmodule

// File: rtl/pll_cfg_slot.sv
// Module: one PLL instance, with staged and live settings and a lock model.
// Staged fields change on register writes while the instance is selected.
// Live fields copy the staged ones on a commit that names this instance.
// The lock counter models settling time after start or ratio change.
// Assumes LOCK_CYCLES >= 2.
module pll_cfg_slot
    import pll_cfg_pkg::*;
#(
    parameter int LOCK_CYCLES = 16,
    localparam int CNT_W      = $clog2(LOCK_CYCLES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              stage_hit,
    input  logic              commit_hit,
    input  logic              wr_ctrla,
    input  logic              wr_ratio,
    input  logic              wr_analog,
    input  logic [DATA_W-1:0] wdata,
    output pll_cfg_t          staged_o,
    output pll_cfg_t          live_o,
    output logic              lock_o
);
    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(LOCK_CYCLES);

    pll_cfg_t         staged_q;
    pll_cfg_t         live_q;
    logic [CNT_W-1:0] cnt_q;
    logic             lock_q;
    logic             ratio_moved;
    logic             restart;

    // Staged copy: field writes land only while this slot is selected.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            staged_q <= '0;
        end else if (stage_hit) begin
            if (wr_ctrla) begin
                staged_q.div     <= wdata[DIV_W-1:0];
                staged_q.div_en  <= wdata[DIVEN_BIT];
                staged_q.pll_en  <= wdata[PLLEN_BIT];
                staged_q.lock_en <= wdata[LOCKEN_BIT];
            end
            if (wr_ratio) begin
                staged_q.mul  <= wdata[DATA_W-1:MUL_LSB];
                staged_q.frac <= wdata[FRAC_W-1:0];
            end
            if (wr_analog) begin
                staged_q.bgap_en <= wdata[BGAP_BIT];
                staged_q.vreg_en <= wdata[VREG_BIT];
            end
        end
    end

    // Live copy: replaced as a whole on commit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            live_q <= '0;
        end else if (commit_hit) begin
            live_q <= staged_q;
        end
    end

    // Decide whether a commit restarts the lock sequence.
    always_comb begin
        ratio_moved = (staged_q.mul != live_q.mul) || (staged_q.frac != live_q.frac);
        restart     = commit_hit && staged_q.pll_en && (!live_q.pll_en || ratio_moved);
    end

    // Lock model: stop, restart, or count down toward lock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            lock_q <= 1'b0;
        end else if (commit_hit && !staged_q.pll_en) begin
            cnt_q  <= '0;
            lock_q <= 1'b0;
        end else if (restart) begin
            cnt_q  <= CNT_LOAD;
            lock_q <= 1'b0;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
            if (cnt_q == CNT_W'(1)) begin
                lock_q <= 1'b1;
            end
        end
    end

    assign staged_o = staged_q;
    assign live_o   = live_q;
    assign lock_o   = lock_q && live_q.lock_en;

    // R7: a commit copies the staged record into the live record.
    assert_commit_copies_R7: assert property (@(posedge clk) disable iff (!rst_n)
        commit_hit |=> (live_q == $past(staged_q)));

    // R8: without a commit the live record holds.
    assert_live_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !commit_hit |=> $stable(live_q));

    // R11: a stop commit clears the lock flag.
    assert_stop_clears_lock_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (commit_hit && !staged_q.pll_en) |=> (!lock_q && !live_q.pll_en));

    // R9: a ratio change on a running PLL drops lock and reloads the count.
    assert_ratio_restart_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (commit_hit && staged_q.pll_en && ratio_moved) |=> (!lock_q && cnt_q == CNT_LOAD));

    // R9: the lock flag rises only as the counter runs out.
    assert_lock_after_count_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lock_q) |-> ($past(cnt_q) == CNT_W'(1)));
endmodule

// File: rtl/pll_cfg_bank.sv
// Module: top of the banked PLL configuration register block.
// Decodes the shared window, builds one slot per instance, flattens the
// live settings onto output ports and muxes read data.
// Assumes 2 <= NUM_PLL <= 16 and a combinational read path.
module pll_cfg_bank
    import pll_cfg_pkg::*;
#(
    parameter int NUM_PLL     = 8,
    parameter int LOCK_CYCLES = 16,
    localparam int SEL_W      = $clog2(NUM_PLL)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      bus_en,
    input  logic                      bus_we,
    input  logic [ADDR_W-1:0]         bus_addr,
    input  logic [DATA_W-1:0]         bus_wdata,
    output logic [DATA_W-1:0]         bus_rdata,
    output logic [NUM_PLL*MUL_W-1:0]  live_mul_o,
    output logic [NUM_PLL*FRAC_W-1:0] live_frac_o,
    output logic [NUM_PLL*DIV_W-1:0]  live_div_o,
    output logic [NUM_PLL-1:0]        div_en_o,
    output logic [NUM_PLL-1:0]        pll_en_o,
    output logic [NUM_PLL-1:0]        bandgap_en_o,
    output logic [NUM_PLL-1:0]        regulator_en_o,
    output logic [NUM_PLL-1:0]        lock_o
);
    logic [SEL_W-1:0] sel;
    logic             wr_ctrla;
    logic             wr_ratio;
    logic             wr_analog;
    logic             commit;
    logic [SEL_W-1:0] commit_id;
    pll_cfg_t         staged [NUM_PLL];
    pll_cfg_t         live   [NUM_PLL];
    logic [NUM_PLL-1:0] lock_vec;

    pll_cfg_decode #(.NUM_PLL(NUM_PLL)) u_decode (
        .clk         (clk),
        .rst_n       (rst_n),
        .bus_en      (bus_en),
        .bus_we      (bus_we),
        .bus_addr    (bus_addr),
        .bus_wdata   (bus_wdata),
        .sel_o       (sel),
        .wr_ctrla_o  (wr_ctrla),
        .wr_ratio_o  (wr_ratio),
        .wr_analog_o (wr_analog),
        .commit_o    (commit),
        .commit_id_o (commit_id)
    );

    for (genvar i = 0; i < NUM_PLL; i++) begin : g_slot
        pll_cfg_slot #(.LOCK_CYCLES(LOCK_CYCLES)) u_slot (
            .clk        (clk),
            .rst_n      (rst_n),
            .stage_hit  (sel == SEL_W'(i)),
            .commit_hit (commit && (commit_id == SEL_W'(i))),
            .wr_ctrla   (wr_ctrla),
            .wr_ratio   (wr_ratio),
            .wr_analog  (wr_analog),
            .wdata      (bus_wdata),
            .staged_o   (staged[i]),
            .live_o     (live[i]),
            .lock_o     (lock_vec[i])
        );

        // Flatten this instance's live settings onto the output ports.
        assign live_mul_o[i*MUL_W +: MUL_W]    = live[i].mul;
        assign live_frac_o[i*FRAC_W +: FRAC_W] = live[i].frac;
        assign live_div_o[i*DIV_W +: DIV_W]    = live[i].div;
        assign div_en_o[i]       = live[i].div_en;
        assign pll_en_o[i]       = live[i].pll_en;
        assign bandgap_en_o[i]   = live[i].bgap_en;
        assign regulator_en_o[i] = live[i].vreg_en;
    end

    assign lock_o = lock_vec;

    // Read mux: staged registers of the selected instance, or status.
    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            OFS_SELECT: bus_rdata[SEL_W-1:0]   = sel;
            OFS_CTRLA:  bus_rdata              = pack_ctrla(staged[sel]);
            OFS_RATIO:  bus_rdata              = pack_ratio(staged[sel]);
            OFS_ANALOG: bus_rdata              = pack_analog(staged[sel]);
            OFS_STATUS: bus_rdata[NUM_PLL-1:0] = lock_vec;
            default:    bus_rdata              = '0;
        endcase
    end

    // R13: at most one instance is committed per cycle.
    assert_single_commit_R13: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(pll_en_o ^ $past(pll_en_o)) <= 1);
endmodule

// File: tb/tb_pll_cfg_bank.sv
`timescale 1ns/1ps
module tb_pll_cfg_bank;
    localparam int NP = 8;
    localparam int LC = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_en = 1'b0;
    logic        bus_we = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [NP*8-1:0]  live_mul_o;
    logic [NP*22-1:0] live_frac_o;
    logic [NP*8-1:0]  live_div_o;
    logic [NP-1:0] div_en_o, pll_en_o, bandgap_en_o, regulator_en_o, lock_o;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #5 clk = ~clk;

    pll_cfg_bank #(.NUM_PLL(NP), .LOCK_CYCLES(LC)) dut (
        .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .live_mul_o(live_mul_o), .live_frac_o(live_frac_o), .live_div_o(live_div_o),
        .div_en_o(div_en_o), .pll_en_o(pll_en_o), .bandgap_en_o(bandgap_en_o),
        .regulator_en_o(regulator_en_o), .lock_o(lock_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_en = 1'b0; bus_we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    // Vector: {write, offset, data}; for reads data is the expected value.
    localparam int NV = 19;
    localparam logic [35:0] VEC [NV] = '{
        {1'b1, 3'd0, 32'h0000_0003},   // R2 select 3
        {1'b0, 3'd0, 32'h0000_0003},   // R2
        {1'b1, 3'd2, 32'hABC0_1234},   // R5 bits 23:22 dropped
        {1'b0, 3'd2, 32'hAB00_1234},   // R5
        {1'b1, 3'd1, 32'hFFFF_F705},   // R4
        {1'b0, 3'd1, 32'h0000_0705},   // R4
        {1'b1, 3'd3, 32'hFFFF_FFFF},   // R6
        {1'b0, 3'd3, 32'h0000_0003},   // R6
        {1'b1, 3'd0, 32'h0000_0009},   // R3 bad id
        {1'b0, 3'd0, 32'h0000_0003},   // R3
        {1'b0, 3'd2, 32'hAB00_1234},   // R3 still instance 3
        {1'b1, 3'd0, 32'h0000_0005},   // R2 select 5
        {1'b0, 3'd2, 32'h0000_0000},   // R4 instance 5 untouched
        {1'b0, 3'd1, 32'h0000_0000},   // R4
        {1'b1, 3'd4, 32'h0000_00FF},   // R12 write ignored
        {1'b0, 3'd4, 32'h0000_0000},   // R12
        {1'b1, 3'd0, 32'h0000_0003},   // R2 back to 3
        {1'b0, 3'd1, 32'h0000_0705},   // R4
        {1'b0, 3'd5, 32'h0000_0000}    // unused offset
    };

    initial begin
        #1_000_000;
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        chk("R1 pll_en", 32'(pll_en_o), 0);
        chk("R1 lock", 32'(lock_o), 0);
        chk("R1 mul", live_mul_o[31:0], 0);
        rd(3'd1, d); chk("R1 ctrla", d, 0);
        rd(3'd0, d); chk("R1 select", d, 0);

        for (int i = 0; i < NV; i++) begin
            if (VEC[i][35]) wr(VEC[i][34:32], VEC[i][31:0]);
            else begin
                rd(VEC[i][34:32], d);
                chk($sformatf("R2-vector %0d", i), d, VEC[i][31:0]);
            end
        end

        // R8: staged writes did not reach the live outputs
        chk("R8 live mul3", 32'(live_mul_o[3*8 +: 8]), 0);
        chk("R8 pll_en", 32'(pll_en_o), 0);

        // R7: commit instance 3
        wr(3'd0, 32'h0000_0103);
        chk("R7 mul3", 32'(live_mul_o[3*8 +: 8]), 32'hAB);
        chk("R7 frac3", 32'(live_frac_o[3*22 +: 22]), 32'h1234);
        chk("R7 div3", 32'(live_div_o[3*8 +: 8]), 5);
        chk("R7 enables", {div_en_o[3], pll_en_o[3], bandgap_en_o[3], regulator_en_o[3]}, 32'hF);
        chk("R7 others", 32'(pll_en_o & 8'hF7), 0);
        chk("R9 lock clear after start", 32'(lock_o[3]), 0);
        repeat (LC - 1) @(negedge clk);
        chk("R9 lock not early", 32'(lock_o[3]), 0);
        @(negedge clk);
        chk("R9 lock on time", 32'(lock_o[3]), 1);
        rd(3'd4, d); chk("R12 status bit3", d, 32'h8);

        // R10: divider-only change keeps lock
        wr(3'd1, 32'h0000_0707);
        wr(3'd0, 32'h0000_0103);
        chk("R10 div live", 32'(live_div_o[3*8 +: 8]), 7);
        chk("R10 lock kept", 32'(lock_o[3]), 1);

        // R9: fraction change restarts lock
        wr(3'd2, 32'hAB00_1235);
        wr(3'd0, 32'h0000_0103);
        chk("R9 restart clear", 32'(lock_o[3]), 0);
        repeat (LC) @(negedge clk);
        chk("R9 relock", 32'(lock_o[3]), 1);

        // R3: bad id with commit bit does nothing
        wr(3'd1, 32'h0000_0005);
        wr(3'd0, 32'h0000_010B);
        chk("R3 no commit", 32'(pll_en_o[3]), 1);
        rd(3'd0, d); chk("R3 selection", d, 3);
        wr(3'd1, 32'h0000_0707);

        // R13 / R12: instance 5 runs without lock-detect enable
        wr(3'd0, 32'h0000_0005);
        wr(3'd1, 32'h0000_0200);
        wr(3'd0, 32'h0000_0105);
        chk("R13 inst3 lock kept", 32'(lock_o[3]), 1);
        chk("R13 inst5 enabled", 32'(pll_en_o[5]), 1);
        repeat (LC + 2) @(negedge clk);
        chk("R12 gated lock", 32'(lock_o[5]), 0);
        wr(3'd1, 32'h0000_0600);
        wr(3'd0, 32'h0000_0105);
        chk("R12 lock shown", 32'(lock_o[5]), 1);
        rd(3'd4, d); chk("R12 status", d, 32'h28);

        // R11: stop instance 3
        wr(3'd0, 32'h0000_0003);
        wr(3'd1, 32'h0000_0405);
        wr(3'd0, 32'h0000_0103);
        chk("R11 lock cleared", 32'(lock_o[3]), 0);
        chk("R11 pll off", 32'(pll_en_o[3]), 0);
        repeat (LC + 2) @(negedge clk);
        chk("R11 stays off", 32'(lock_o[3]), 0);
        chk("R13 inst5 unaffected", 32'(lock_o[5]), 1);

        // R1: reset mid-run
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        chk("R1 lock after reset", 32'(lock_o), 0);
        chk("R1 mul after reset", 32'(live_mul_o[5*8 +: 8] | live_mul_o[3*8 +: 8]), 0);
        rd(3'd2, d); chk("R1 ratio after reset", d, 0);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule